// File: doc/BRIEF.md
# Edge-Selective Counted Delay

This block holds back chosen transitions of a single-bit signal for a programmable number of counting ticks. Each input edge is classed as rising or falling. A mode field says which of the two classes are held. A held edge reaches the output only after the tick counter has run down from the programmed count. An edge that is not held is copied to the output at the next clock edge, with no counting.

Ticks come from one of three enables. The first is the base clock itself, where every cycle is a tick. The second is a free-running prescaler that divides the base clock by 1, 2, 4 or 8. The third is an external clock pin; it passes through two synchronizing flops, and each of its rising edges becomes one tick. A long delay comes from a large count paired with a slow tick. For example, a 25 kHz tick and a count of 125 give 5 ms.

If the input goes back to the output's level before a held edge has finished counting, that edge is dropped. A later held edge always starts a fresh count.

Top module: `edge_delay_ctr`

## Requirements
- R1: While `rst` is high at a clock edge, `dout` clears to 0 and any held edge is discarded. Afterwards `dout` stays 0 while `din` stays 0.
- R2: On the base tick (`clk_sel` = 0 or 3), assume `din` changes to a held level just before clock edge E0. Then `dout` takes that level at edge E0+N, where N is `delay_cnt`, and not earlier.
- R3: A `delay_cnt` of 0 behaves exactly like a count of 1.
- R4: `mode` bit 0 set holds rising edges, and `mode` bit 1 set holds falling edges. A transition whose bit is clear appears on `dout` at the first clock edge that samples it.
- R5: With `mode` = 0, both edges pass through at the first sampling edge.
- R6: If `din` returns to the current `dout` level while an edge is held, the held edge is dropped and `dout` does not change.
- R7: A held edge that is dropped and then presented again restarts from the full count. It reaches `dout` N ticks after the new transition.
- R8: With `clk_sel` = 1, ticks come once every 2^`div_sel` base cycles from a prescaler that runs freely from reset. A held edge then appears between (N-1)·R+1 and N·R cycles after its sampling edge, where R = 2^`div_sel`.
- R9: With `clk_sel` = 2, each rising edge of `ext_clk` gives one tick after two synchronizing flops. With no `ext_clk` edges, a held edge never completes.
- R10: The counter is not allowed to sit at zero while an edge is held. N = 255 produces a delay of exactly 255 base ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Signal to delay |
| delay_cnt | input | 8 | Tick count for held edges (0 acts as 1) |
| mode | input | 2 | Bit 0 holds rising edges, bit 1 holds falling edges |
| clk_sel | input | 2 | Tick source: 0 base, 1 divided, 2 external, 3 base |
| div_sel | input | 2 | Divider ratio 2^div_sel (1, 2, 4, 8) |
| ext_clk | input | 1 | External tick clock, asynchronous |
| dout | output | 1 | Delayed signal |

## Verification
A counter that is off by one shows up on `dout` as an edge that arrives one cycle early or late. For this reason the base-tick tests sample `dout` on both sides of the expected edge. A hold flag stuck high would freeze `dout` at the next transition. A lost cancel would make a short glitch appear on `dout` a full delay later, so the glitch tests watch `dout` for the whole count and a few cycles beyond. A wrong divider or synchronizer tap moves the arrival time by whole tick periods. These faults therefore show up within one delay window.

// File: rtl/edge_delay_ctr.sv
module edge_delay_ctr #(
  parameter int CNT_W = 8,
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  input  logic [CNT_W-1:0] delay_cnt,
  input  logic [1:0]       mode,
  input  logic [1:0]       clk_sel,
  input  logic [DIV_W-1:0] div_sel,
  input  logic             ext_clk,
  output logic             dout
);
  localparam int PRE_W = (1 << DIV_W) - 1;

  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] pre_mask;
  logic [2:0]       ext_sh;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] load_val;
  logic             pending;
  logic             div_tick, ext_tick, tick, want_hold;

  assign pre_mask  = ~({PRE_W{1'b1}} << div_sel);
  assign div_tick  = (pre & pre_mask) == pre_mask;
  assign ext_tick  = ext_sh[1] & ~ext_sh[2];
  assign load_val  = (delay_cnt == '0) ? CNT_W'(1) : delay_cnt;
  assign want_hold = din ? mode[0] : mode[1];

  always_comb begin
    case (clk_sel)
      2'd1:    tick = div_tick;
      2'd2:    tick = ext_tick;
      default: tick = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre    <= '0;
      ext_sh <= '0;
    end else begin
      pre    <= pre + PRE_W'(1);
      ext_sh <= {ext_sh[1:0], ext_clk};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout    <= 1'b0;
      pending <= 1'b0;
      cnt     <= '0;
    end else if (din == dout) begin
      pending <= 1'b0;
    end else if (!pending) begin
      if (want_hold) begin
        pending <= 1'b1;
        cnt     <= load_val;
      end else begin
        dout <= din;
      end
    end else if (tick) begin
      if (cnt == CNT_W'(1)) begin
        dout    <= din;
        pending <= 1'b0;
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!dout && !pending));

  a_r4_out_follows_in: assert property (@(posedge clk) disable iff (rst)
    !$stable(dout) |-> (dout == $past(din)));

  a_r5_pass_unheld: assert property (@(posedge clk) disable iff (rst)
    (!pending && din != dout && !want_hold) |=> (dout == $past(din)));

  a_r6_cancel_on_return: assert property (@(posedge clk) disable iff (rst)
    (pending && din == dout) |=> (!pending && $stable(dout)));

  a_r10_cnt_nonzero: assert property (@(posedge clk) disable iff (rst)
    pending |-> (cnt != '0));

  a_r9_no_tick_hold: assert property (@(posedge clk) disable iff (rst)
    (pending && !tick && din != dout) |=> $stable(dout));

endmodule

// File: tb/edge_delay_ctr_tb.sv
module edge_delay_ctr_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       din = 1'b0;
  logic [7:0] delay_cnt = 8'd1;
  logic [1:0] mode = 2'd0;
  logic [1:0] clk_sel = 2'd0;
  logic [1:0] div_sel = 2'd0;
  logic       ext_clk = 1'b0;
  logic       dout;
  int         vecs = 0;
  int         errs = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  edge_delay_ctr dut_i (
    .clk(clk), .rst(rst), .din(din), .delay_cnt(delay_cnt), .mode(mode),
    .clk_sel(clk_sel), .div_sel(div_sel), .ext_clk(ext_clk), .dout(dout)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle();
    mode = 2'd0; clk_sel = 2'd0; din = 1'b0;
    waitn(3);
  endtask

  task automatic t_reset();
    rst = 1'b1; waitn(3); rst = 1'b0; waitn(2);
    chk(dout == 1'b0, "R1 reset", dout, 0);
  endtask

  task automatic t_pass_all();
    settle();
    din = 1'b1; waitn(1);
    chk(dout == 1'b1, "R5 rise pass", dout, 1);
    din = 1'b0; waitn(1);
    chk(dout == 1'b0, "R5 fall pass", dout, 0);
  endtask

  task automatic t_rise_hold();
    settle();
    mode = 2'd1; delay_cnt = 8'd6;
    din = 1'b1; waitn(6);
    chk(dout == 1'b0, "R2 rise early", dout, 0);
    waitn(1);
    chk(dout == 1'b1, "R2 rise on time", dout, 1);
    din = 1'b0; waitn(1);
    chk(dout == 1'b0, "R4 fall unheld", dout, 0);
  endtask

  task automatic t_fall_hold();
    settle();
    mode = 2'd2; delay_cnt = 8'd2;
    din = 1'b1; waitn(1);
    chk(dout == 1'b1, "R4 rise unheld", dout, 1);
    din = 1'b0; waitn(2);
    chk(dout == 1'b1, "R4 fall early", dout, 1);
    waitn(1);
    chk(dout == 1'b0, "R4 fall on time", dout, 0);
  endtask

  task automatic t_zero();
    settle();
    mode = 2'd1; delay_cnt = 8'd0;
    din = 1'b1; waitn(1);
    chk(dout == 1'b0, "R3 zero early", dout, 0);
    waitn(1);
    chk(dout == 1'b1, "R3 zero acts as one", dout, 1);
  endtask

  task automatic t_max();
    settle();
    mode = 2'd3; delay_cnt = 8'd255;
    din = 1'b1; waitn(255);
    chk(dout == 1'b0, "R10 max early", dout, 0);
    waitn(1);
    chk(dout == 1'b1, "R10 max on time", dout, 1);
  endtask

  task automatic t_cancel();
    int bad;
    settle();
    mode = 2'd1; delay_cnt = 8'd5;
    din = 1'b1; waitn(3);
    din = 1'b0;
    bad = 0;
    for (int i = 0; i < 10; i++) begin
      waitn(1);
      if (dout) bad++;
    end
    chk(bad == 0, "R6 glitch dropped", bad, 0);
  endtask

  task automatic t_restart();
    settle();
    mode = 2'd3; delay_cnt = 8'd4;
    din = 1'b1; waitn(3);
    din = 1'b0; waitn(1);
    din = 1'b1; waitn(4);
    chk(dout == 1'b0, "R7 restart early", dout, 0);
    waitn(1);
    chk(dout == 1'b1, "R7 restart on time", dout, 1);
  endtask

  task automatic t_div(input logic [1:0] dsel, input int n);
    int k, r, lo, hi;
    settle();
    mode = 2'd1; delay_cnt = 8'(n); clk_sel = 2'd1; div_sel = dsel;
    r = 1 << dsel;
    lo = (n - 1) * r + 2; hi = n * r + 1;
    din = 1'b1;
    k = 0;
    while (!dout && k < 200) begin
      waitn(1); k++;
    end
    chk(k >= lo && k <= hi, "R8 divided delay", k, lo);
  endtask

  task automatic ext_pulse();
    ext_clk = 1'b1; waitn(3);
    ext_clk = 1'b0; waitn(3);
  endtask

  task automatic t_ext();
    settle();
    mode = 2'd1; delay_cnt = 8'd3; clk_sel = 2'd2;
    din = 1'b1; waitn(12);
    chk(dout == 1'b0, "R9 no ext edges", dout, 0);
    ext_pulse(); ext_pulse();
    chk(dout == 1'b0, "R9 two ext ticks", dout, 0);
    ext_pulse();
    chk(dout == 1'b1, "R9 third ext tick", dout, 1);
  endtask

  initial begin
    t_reset();
    t_pass_all();
    t_rise_hold();
    t_fall_hold();
    t_zero();
    t_max();
    t_cancel();
    t_restart();
    t_div(2'd2, 3);
    t_div(2'd3, 2);
    t_div(2'd1, 5);
    t_ext();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      vecs++; errs++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule